// File: doc/BRIEF.md
# Skew Polarity Decision Cell

This cell decides, once per acquisition, whether a channel sampling event arrived before or after the matching reference event. It is synchronous logic. A fast clock samples two single-cycle strobes, one for the channel event and one for the reference event. A one-hot vector of phase-window levels from a four-phase sequencer marks where each acquisition starts and ends.

The phase just before this channel's own phase is the arming phase. While it is high, all decision state is held clear. Once it ends, the first strobe to arrive is captured, and the other side is locked out until the next arming phase. The phase just after the channel's own phase is the deadline. At its rising edge the capture window closes. If no side has been captured by then, a forced default of "reference leads" is asserted. A one-cycle valid strobe then tells a downstream up/down counter to take exactly one step for this acquisition.

Top module: `skew_polarity_cell`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge.
- R2: A clock edge at which the arming phase is high clears `ch_lead_o`, `ref_lead_o` and `forced_o` to 0, and events sampled at that edge are ignored.
- R3: In an open window with no prior decision, an edge that samples `chan_evt_i` high and `ref_evt_i` low sets `ch_lead_o`=1 and `ref_lead_o`=0 after that edge.
- R4: In an open window with no prior decision, an edge that samples `ref_evt_i` high and `chan_evt_i` low sets `ref_lead_o`=1 and `ch_lead_o`=0 after that edge.
- R5: Once one side is captured, events from the other side do not change the outputs before the next arming phase, and the two lead outputs are never both 1.
- R6: If both strobes are sampled high at the same edge in an open window with no prior decision, nothing is captured and both lead outputs stay 0.
- R7: At the edge where the deadline phase rises, if no side has been captured, `forced_o`=1, `ref_lead_o`=1 and `ch_lead_o`=0 from then until the next arming edge.
- R8: `dec_valid_o` is high for exactly one cycle, right after the edge where the deadline phase rises. This gives one pulse per acquisition, however long the deadline phase stays high.
- R9: The window is closed from the deadline rising edge (inclusive) until the next arming edge, and strobes sampled while it is closed have no effect.
- R10: Bit k of `phase_i` is phase k. The arming phase is phase `CHAN_IDX-1`, the deadline phase is phase `CHAN_IDX+1` (both modulo `NUM_PHASES`), and with the defaults these are bits 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | NUM_PHASES | One-hot phase-window levels, bit k = phase k |
| chan_evt_i | input | 1 | Single-cycle channel event strobe |
| ref_evt_i | input | 1 | Single-cycle reference event strobe |
| ch_lead_o | output | 1 | Channel event came first |
| ref_lead_o | output | 1 | Reference event came first, or forced default |
| forced_o | output | 1 | No side resolved before the deadline |
| dec_valid_o | output | 1 | One-cycle strobe: decision final for this acquisition |

## Verification
Directed acquisitions place a lone channel strobe, a lone reference strobe, both strobes in one cycle, the two strobes in succession in each order, no strobe at all, and strobes inside the arming phase or after the deadline. These cases separate a correct first-arrival capture from a last-arrival or ungated one, and a true tie from a resolved race. Seeded random acquisitions then scatter zero, one or two strobes over the whole acquisition, including its edges, and every cycle is compared with a bench model. A mid-acquisition reset and an acquisition whose deadline phase is stretched show whether the state clears properly and whether the valid strobe stays at one pulse.

// File: rtl/skew_cell_pkg.sv
package skew_cell_pkg;
  // Phase index reached by stepping `delta` phases from `base`, wrapped.
  function automatic int wrap_phase(input int base, input int delta, input int n);
    int r;
    r = (base + delta) % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

  // Output pair from the capture state and the forced flag.
  function automatic logic [1:0] lead_pair(input logic cap_chan, input logic cap_ref,
                                           input logic forced);
    // [1] = channel leads, [0] = reference leads
    return {cap_chan & ~forced, cap_ref | forced};
  endfunction
endpackage

// File: rtl/phase_window_decode.sv
module phase_window_decode #(
  parameter int NUM_PHASES = 4,
  parameter int ARM_PH     = 0,
  parameter int DL_PH      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase_i,
  output logic                  arm_o,
  output logic                  dl_rise_o
);
  logic dl_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) dl_prev_q <= 1'b0;
    else        dl_prev_q <= phase_i[DL_PH];
  end

  assign arm_o     = phase_i[ARM_PH];
  assign dl_rise_o = phase_i[DL_PH] & ~dl_prev_q & ~phase_i[ARM_PH];
endmodule

// File: rtl/first_arrival_capture.sv
module first_arrival_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic window_open_i,
  input  logic chan_evt_i,
  input  logic ref_evt_i,
  output logic cap_chan_o,
  output logic cap_ref_o
);
  logic undecided;
  logic take_chan, take_ref;

  assign undecided = ~cap_chan_o & ~cap_ref_o;
  // A tie leaves both unset; the deadline resolves it.
  assign take_chan = window_open_i & undecided & chan_evt_i & ~ref_evt_i;
  assign take_ref  = window_open_i & undecided & ref_evt_i & ~chan_evt_i;

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i) begin
      cap_chan_o <= 1'b0;
      cap_ref_o  <= 1'b0;
    end else begin
      if (take_chan) cap_chan_o <= 1'b1;
      if (take_ref)  cap_ref_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/deadline_resolver.sv
module deadline_resolver (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic dl_rise_i,
  input  logic decided_i,
  output logic closed_o,
  output logic forced_o,
  output logic valid_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      closed_o <= 1'b0;
      forced_o <= 1'b0;
      valid_o  <= 1'b0;
    end else if (arm_i) begin
      closed_o <= 1'b0;
      forced_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= dl_rise_i;
      if (dl_rise_i) begin
        closed_o <= 1'b1;
        if (!decided_i) forced_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/skew_polarity_cell.sv
module skew_polarity_cell
  import skew_cell_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int CHAN_IDX   = 1,
  parameter int ARM_BACK   = 1,
  parameter int DL_AHEAD   = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] phase_i,
  input  logic                  chan_evt_i,
  input  logic                  ref_evt_i,
  output logic                  ch_lead_o,
  output logic                  ref_lead_o,
  output logic                  forced_o,
  output logic                  dec_valid_o
);
  localparam int ARM_PH = wrap_phase(CHAN_IDX, -ARM_BACK, NUM_PHASES);
  localparam int DL_PH  = wrap_phase(CHAN_IDX, DL_AHEAD, NUM_PHASES);

  logic arm_w, dl_rise_w, window_open_w, closed_w;
  logic cap_chan_w, cap_ref_w, forced_w;
  logic [1:0] pair_w;

  phase_window_decode #(
    .NUM_PHASES(NUM_PHASES), .ARM_PH(ARM_PH), .DL_PH(DL_PH)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i),
    .arm_o(arm_w), .dl_rise_o(dl_rise_w)
  );

  assign window_open_w = ~arm_w & ~closed_w & ~dl_rise_w;

  first_arrival_capture u_cap (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_w), .window_open_i(window_open_w),
    .chan_evt_i(chan_evt_i), .ref_evt_i(ref_evt_i),
    .cap_chan_o(cap_chan_w), .cap_ref_o(cap_ref_w)
  );

  deadline_resolver u_res (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_w), .dl_rise_i(dl_rise_w),
    .decided_i(cap_chan_w | cap_ref_w),
    .closed_o(closed_w), .forced_o(forced_w), .valid_o(dec_valid_o)
  );

  assign pair_w     = lead_pair(cap_chan_w, cap_ref_w, forced_w);
  assign ch_lead_o  = pair_w[1];
  assign ref_lead_o = pair_w[0];
  assign forced_o   = forced_w;
endmodule

// File: rtl/skew_cell_checker.sv
module skew_cell_checker (
  input logic clk,
  input logic rst_n,
  input logic arm_w,
  input logic dl_rise_w,
  input logic window_open_w,
  input logic chan_evt_i,
  input logic ref_evt_i,
  input logic ch_lead_o,
  input logic ref_lead_o,
  input logic forced_o,
  input logic dec_valid_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !ch_lead_o && !ref_lead_o && !forced_o && !dec_valid_o);
  a_r2_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    arm_w |=> !ch_lead_o && !ref_lead_o && !forced_o);
  a_r3_chan_first: assert property (@(posedge clk) disable iff (!rst_n)
    window_open_w && chan_evt_i && !ref_evt_i && !ch_lead_o && !ref_lead_o
    |=> ch_lead_o && !ref_lead_o);
  a_r4_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
    window_open_w && ref_evt_i && !chan_evt_i && !ch_lead_o && !ref_lead_o
    |=> ref_lead_o && !ch_lead_o);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_lead_o && ref_lead_o));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ch_lead_o && !arm_w |=> ch_lead_o);
  a_r6_tie: assert property (@(posedge clk) disable iff (!rst_n)
    window_open_w && chan_evt_i && ref_evt_i && !ch_lead_o && !ref_lead_o
    |=> !ch_lead_o && !ref_lead_o);
  a_r7_force: assert property (@(posedge clk) disable iff (!rst_n)
    dl_rise_w && !ch_lead_o && !ref_lead_o |=> forced_o && ref_lead_o && !ch_lead_o);
  a_r7_forced_pair: assert property (@(posedge clk) disable iff (!rst_n)
    forced_o |-> ref_lead_o && !ch_lead_o);
  a_r8_valid_once: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |=> !dec_valid_o);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dl_rise_w |=> dec_valid_o);
  a_r9_closed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open_w && !arm_w && !dl_rise_w |=> $stable(ch_lead_o) && $stable(ref_lead_o));
endmodule

bind skew_polarity_cell skew_cell_checker u_chk (
  .clk(clk), .rst_n(rst_n), .arm_w(arm_w), .dl_rise_w(dl_rise_w),
  .window_open_w(window_open_w), .chan_evt_i(chan_evt_i), .ref_evt_i(ref_evt_i),
  .ch_lead_o(ch_lead_o), .ref_lead_o(ref_lead_o), .forced_o(forced_o),
  .dec_valid_o(dec_valid_o)
);

// File: tb/tb_skew_polarity_cell.sv
module tb_skew_polarity_cell;
  localparam int NP = 4;
  localparam int PH_LEN = 4;
  localparam int ACQ = NP * PH_LEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] phase = '0;
  logic chan_evt = 1'b0, ref_evt = 1'b0;
  logic ch_lead, ref_lead, forced, dec_valid;

  int checks = 0, errors = 0, vpulses = 0;
  bit done = 0;

  // Bench model state (R10: arm = bit 0, deadline = bit 2)
  logic m_chan = 0, m_ref = 0, m_forced = 0, m_closed = 0, m_valid = 0, m_prev = 0;

  always #4 clk = ~clk;

  skew_polarity_cell dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .chan_evt_i(chan_evt),
    .ref_evt_i(ref_evt), .ch_lead_o(ch_lead), .ref_lead_o(ref_lead),
    .forced_o(forced), .dec_valid_o(dec_valid)
  );

  function automatic logic [3:0] expect_out(input logic c, input logic r,
                                            input logic f, input logic v);
    return {c & ~f, r | f, f, v};
  endfunction

  always @(posedge clk) begin
    logic rise;
    rise = phase[2] && !m_prev && !phase[0];
    m_prev <= rst_n ? phase[2] : 1'b0;
    if (!rst_n || phase[0]) begin
      m_chan <= 0; m_ref <= 0; m_forced <= 0; m_closed <= 0; m_valid <= 0;
    end else begin
      m_valid <= rise;
      if (rise) begin
        m_closed <= 1;
        if (!m_chan && !m_ref) m_forced <= 1;
      end else if (!m_closed && !m_chan && !m_ref) begin
        if (chan_evt && !ref_evt) m_chan <= 1;
        if (ref_evt && !chan_evt) m_ref <= 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string step_tag(input int s);
    if (s < PH_LEN) return "R2 R10 arming";
    if (s < 2*PH_LEN) return "R3 R4 R5 R6 window";
    if (s == 2*PH_LEN) return "R7 R8 deadline";
    return "R8 R9 closed";
  endfunction

  // One acquisition; ct/rt = step of channel/reference strobe, -1 = none.
  task automatic acquire(input int ct, input int rt, input int dl_extra);
    for (int s = 0; s < ACQ + dl_extra; s++) begin
      int ps;
      @(negedge clk);
      chk(step_tag(s == 0 ? ACQ : s - 1), {ch_lead, ref_lead, forced, dec_valid},
          expect_out(m_chan, m_ref, m_forced, m_valid));
      if (dec_valid) vpulses++;
      ps = s;
      if (s >= 2*PH_LEN && s < 3*PH_LEN + dl_extra) ps = 2*PH_LEN;
      else if (s >= 3*PH_LEN + dl_extra) ps = s - dl_extra;
      phase = '0;
      phase[ps / PH_LEN] = 1'b1;
      chan_evt = (s == ct);
      ref_evt = (s == rt);
    end
  endtask

  task automatic final_out(input string tag, input logic [3:0] exp);
    @(negedge clk);
    chk(tag, {ch_lead, ref_lead, forced, dec_valid}, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {ch_lead, ref_lead, forced, dec_valid}, 4'b0000);
    rst_n = 1'b1;

    // R3: lone channel strobe in window
    acquire(5, -1, 0);  final_out("R3 channel leads", 4'b1000);
    // R4: lone reference strobe
    acquire(-1, 6, 0);  final_out("R4 reference leads", 4'b0100);
    // R5: channel then reference; reference then channel
    acquire(4, 6, 0);   final_out("R5 first blocks second", 4'b1000);
    acquire(7, 5, 0);   final_out("R5 first blocks second", 4'b0100);
    // R6: tie, then forced at deadline
    acquire(6, 6, 0);   final_out("R6 R7 tie forced", 4'b0110);
    // R7: no strobes
    acquire(-1, -1, 0); final_out("R7 no event forced", 4'b0110);
    // R2/R9: strobes only during arming or after deadline
    acquire(2, 12, 0);  final_out("R2 R9 ignored strobes", 4'b0110);
    acquire(8, 8, 0);   final_out("R9 deadline edge strobes", 4'b0110);
    // R8: stretched deadline phase, single valid pulse
    vpulses = 0;
    acquire(5, -1, 6);
    @(negedge clk);
    chk("R8 one valid pulse", 4'(vpulses), 4'd1);

    // R1: reset mid-acquisition after a capture
    acquire(-1, 5, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", {ch_lead, ref_lead, forced, dec_valid}, 4'b0000);
    rst_n = 1'b1;

    // Random acquisitions
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      int ct, rt;
      ct = ($urandom % 3 == 0) ? -1 : int'($urandom % ACQ);
      rt = ($urandom % 3 == 0) ? -1 : int'($urandom % ACQ);
      if ($urandom % 8 == 0) rt = ct;
      acquire(ct, rt, int'($urandom % 3));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule